// File: doc/BRIEF.md
# Zone-Ranked Replacement Controller

This block picks the way to evict in one set of a set-associative shared last-level cache. Each way keeps a 3-bit saturating reuse counter. The counter places its line in one of four priority zones. From lowest to highest, the zones are: never expected back, unlikely, likely, and most likely to be referenced again.

A hit lifts the line by one zone. A fill installs the line in the second-lowest zone. A periodic demotion tick lowers every valid line by one zone, so lines that are no longer used drift down. The victim search looks at empty ways first. It then walks the zones upward from the lowest. Inside the first non-empty zone, the lowest-numbered way is chosen.

The victim output is combinational from the stored counter and valid state. The tag lookup can therefore use it in the same cycle as a miss. An invalidate port lets the surrounding tag store clear a way's valid bit.

Top module: `zr_repl_ctrl`

## Requirements
- R1: After reset, every way is invalid and every counter is 0, so the victim is way 0.
- R2: A fill to a way makes it valid with counter 2. While any way is invalid, the victim is the lowest-numbered invalid way.
- R3: Zone = counter / 2. The value pairs 0-1, 2-3, 4-5 and 6-7 map to zones 0 to 3. With all ways valid, the victim is the lowest-numbered way in the lowest occupied zone.
- R4: A hit on a valid way adds 2 to its counter, saturating at 7.
- R5: A demotion tick subtracts 2 from every valid way's counter, saturating at 0.
- R6: When a hit and a tick land on the same valid way in one cycle, the demotion is applied first and the hit second.
- R7: An invalidate clears the way's valid bit and sets its counter to 0. It takes priority over a fill or hit to the same way in the same cycle.
- R8: A hit on an invalid way has no effect.
- R9: A fill and a hit to the same way in one cycle leave the counter at 2.
- R10: victim_valid is 0 while rst is high and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_en | input | 1 | A lookup hit a way this cycle |
| hit_way | input | WAY_W | Way that hit |
| fill_en | input | 1 | A line is installed this cycle |
| fill_way | input | WAY_W | Way being filled |
| inv_en | input | 1 | Clear a way's valid bit |
| inv_way | input | WAY_W | Way being invalidated |
| demote_tick | input | 1 | Periodic aging pulse |
| victim_way | output | WAY_W | Way to replace |
| victim_valid | output | 1 | Victim output is usable |

## Verification
Some properties are checked on every cycle. The counter arithmetic is checked for a lone hit, a lone tick, the combined hit-and-tick case and a fill. An invalid way must hold counter 0. An empty way must be chosen before any valid way, and no valid way may sit in a lower zone than the victim or tie with it at a lower index. The bench scenarios are what show saturation at both ends, the tie-breaking order after uniform promotion, the priority of the same-cycle operation mixes and the ignored hit on an empty way. These results only become visible through victim choices several cycles later.

// File: rtl/zr_pkg.sv
package zr_pkg;
    localparam int CNT_W     = 3;
    localparam int CNT_MAX   = 7;
    localparam int STEP      = 2;
    localparam int FILL_INIT = 2;
    localparam int ZONE_W    = 2;
    localparam int NZONES    = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [ZONE_W-1:0] {
        ZN_NEVER  = 2'd0,
        ZN_LESS   = 2'd1,
        ZN_LIKELY = 2'd2,
        ZN_MOST   = 2'd3
    } zone_e;

    function automatic zone_e zone_of(cnt_t c);
        return zone_e'(c[CNT_W-1 -: ZONE_W]);
    endfunction

    function automatic cnt_t sat_up(cnt_t c);
        if (int'(c) > CNT_MAX - STEP) return cnt_t'(CNT_MAX);
        return cnt_t'(int'(c) + STEP);
    endfunction

    function automatic cnt_t sat_down(cnt_t c);
        if (int'(c) < STEP) return '0;
        return cnt_t'(int'(c) - STEP);
    endfunction
endpackage

// File: rtl/zr_op_decode.sv
module zr_op_decode #(
    parameter int WAYS  = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             en,
    input  logic [WAY_W-1:0] way,
    output logic [WAYS-1:0]  onehot
);
    for (genvar i = 0; i < WAYS; i++) begin : g_dec
        assign onehot[i] = en && (way == WAY_W'(i));
    end
endmodule

// File: rtl/zr_counter_bank.sv
module zr_counter_bank
    import zr_pkg::*;
#(
    parameter int WAYS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WAYS-1:0]       hit_vec,
    input  logic [WAYS-1:0]       fill_vec,
    input  logic [WAYS-1:0]       inv_vec,
    input  logic                  tick,
    output cnt_t [WAYS-1:0]       cnt,
    output logic [WAYS-1:0]       vld
);
    for (genvar i = 0; i < WAYS; i++) begin : g_way
        cnt_t aged, nxt;

        always_comb begin
            aged = tick ? sat_down(cnt[i]) : cnt[i];
            nxt  = hit_vec[i] ? sat_up(aged) : aged;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[i] <= '0;
                vld[i] <= 1'b0;
            end else if (inv_vec[i]) begin
                cnt[i] <= '0;
                vld[i] <= 1'b0;
            end else if (fill_vec[i]) begin
                cnt[i] <= cnt_t'(FILL_INIT);
                vld[i] <= 1'b1;
            end else if (vld[i]) begin
                cnt[i] <= nxt;
            end
        end

        assert_inv_zero_R7: assert property (@(posedge clk) disable iff (rst)
            !vld[i] |-> (cnt[i] == '0));

        assert_fill_init_R2: assert property (@(posedge clk) disable iff (rst)
            (fill_vec[i] && !inv_vec[i]) |=> (vld[i] && cnt[i] == 3'd2));

        assert_hit_step_R4: assert property (@(posedge clk) disable iff (rst)
            (vld[i] && hit_vec[i] && !tick && !fill_vec[i] && !inv_vec[i]) |=>
            (cnt[i] == (($past(cnt[i]) >= 3'd6) ? 3'd7 : $past(cnt[i]) + 3'd2)));

        assert_tick_step_R5: assert property (@(posedge clk) disable iff (rst)
            (vld[i] && tick && !hit_vec[i] && !fill_vec[i] && !inv_vec[i]) |=>
            (cnt[i] == (($past(cnt[i]) < 3'd2) ? 3'd0 : $past(cnt[i]) - 3'd2)));

        assert_tick_then_hit_R6: assert property (@(posedge clk) disable iff (rst)
            (vld[i] && tick && hit_vec[i] && !fill_vec[i] && !inv_vec[i]) |=>
            (cnt[i] == (($past(cnt[i]) < 3'd2) ? 3'd2 : $past(cnt[i]))));
    end
endmodule

// File: rtl/zr_victim_sel.sv
module zr_victim_sel
    import zr_pkg::*;
#(
    parameter int WAYS  = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  cnt_t [WAYS-1:0]  cnt,
    input  logic [WAYS-1:0]  vld,
    output logic [WAY_W-1:0] victim
);
    logic found;

    always_comb begin
        found  = 1'b0;
        victim = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (!found && !vld[i]) begin
                victim = WAY_W'(i);
                found  = 1'b1;
            end
        end
        for (int z = 0; z < NZONES; z++) begin
            for (int i = 0; i < WAYS; i++) begin
                if (!found && vld[i] && int'(zone_of(cnt[i])) == z) begin
                    victim = WAY_W'(i);
                    found  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/zr_repl_ctrl.sv
module zr_repl_ctrl
    import zr_pkg::*;
#(
    parameter int WAYS  = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_en,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             inv_en,
    input  logic [WAY_W-1:0] inv_way,
    input  logic             demote_tick,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_valid
);
    logic [WAYS-1:0] hit_vec, fill_vec, inv_vec, vld;
    cnt_t [WAYS-1:0] cnt;

    zr_op_decode #(.WAYS(WAYS)) u_dec_hit  (.en(hit_en),  .way(hit_way),  .onehot(hit_vec));
    zr_op_decode #(.WAYS(WAYS)) u_dec_fill (.en(fill_en), .way(fill_way), .onehot(fill_vec));
    zr_op_decode #(.WAYS(WAYS)) u_dec_inv  (.en(inv_en),  .way(inv_way),  .onehot(inv_vec));

    zr_counter_bank #(.WAYS(WAYS)) u_bank (
        .clk(clk), .rst(rst), .hit_vec(hit_vec), .fill_vec(fill_vec),
        .inv_vec(inv_vec), .tick(demote_tick), .cnt(cnt), .vld(vld)
    );

    zr_victim_sel #(.WAYS(WAYS)) u_sel (.cnt(cnt), .vld(vld), .victim(victim_way));

    assign victim_valid = !rst;

    // Checker logic: no valid way ranks strictly below the victim, nor ties at a lower index.
    logic rank_ok;
    always_comb begin
        rank_ok = 1'b1;
        for (int i = 0; i < WAYS; i++) begin
            if (cnt[i][CNT_W-1:1] < cnt[victim_way][CNT_W-1:1]) rank_ok = 1'b0;
            if (WAY_W'(i) < victim_way && cnt[i][CNT_W-1:1] == cnt[victim_way][CNT_W-1:1])
                rank_ok = 1'b0;
        end
    end

    assert_empty_first_R2: assert property (@(posedge clk) disable iff (rst)
        (!(&vld)) |-> !vld[victim_way]);

    assert_lowest_zone_R3: assert property (@(posedge clk) disable iff (rst)
        (&vld) |-> rank_ok);
endmodule

// File: tb/zr_repl_ctrl_tb.sv
module zr_repl_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hit_en = 0, fill_en = 0, inv_en = 0, demote_tick = 0;
    logic [2:0] hit_way = 0, fill_way = 0, inv_way = 0;
    logic [2:0] victim_way;
    logic victim_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    zr_repl_ctrl #(.WAYS(WAYS)) u_dut (
        .clk(clk), .rst(rst), .hit_en(hit_en), .hit_way(hit_way),
        .fill_en(fill_en), .fill_way(fill_way), .inv_en(inv_en), .inv_way(inv_way),
        .demote_tick(demote_tick), .victim_way(victim_way), .victim_valid(victim_valid)
    );

    typedef struct {
        int         due;
        logic [2:0] way;
        logic       vv;
        string      tag;
    } exp_t;

    exp_t q[$];
    int cyc = 0;
    int checks = 0, fails = 0;
    bit done = 0;
    int m_cnt [WAYS];
    bit m_vld [WAYS];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [2:0] model_victim();
        for (int i = 0; i < WAYS; i++) if (!m_vld[i]) return 3'(i);
        for (int z = 0; z < 4; z++)
            for (int i = 0; i < WAYS; i++) if (m_cnt[i] / 2 == z) return 3'(i);
        return 3'd0;
    endfunction

    task automatic step(input bit h, input int hw, input bit f, input int fw,
                        input bit iv, input int iw, input bit t, input string tag);
        exp_t e;
        @(posedge clk); #1;
        hit_en = h; hit_way = 3'(hw); fill_en = f; fill_way = 3'(fw);
        inv_en = iv; inv_way = 3'(iw); demote_tick = t;
        for (int i = 0; i < WAYS; i++) begin
            if (iv && iw == i) begin m_cnt[i] = 0; m_vld[i] = 0; end
            else if (f && fw == i) begin m_cnt[i] = 2; m_vld[i] = 1; end
            else if (m_vld[i]) begin
                if (t) m_cnt[i] = (m_cnt[i] < 2) ? 0 : m_cnt[i] - 2;
                if (h && hw == i) m_cnt[i] = (m_cnt[i] > 5) ? 7 : m_cnt[i] + 2;
            end
        end
        e.due = cyc + 1; e.way = model_victim(); e.vv = 1'b1; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic hit(input int w, input string tag);   step(1, w, 0, 0, 0, 0, 0, tag); endtask
    task automatic fill(input int w, input string tag);  step(0, 0, 1, w, 0, 0, 0, tag); endtask
    task automatic tick(input string tag);               step(0, 0, 0, 0, 0, 0, 1, tag); endtask
    task automatic idle(input string tag);               step(0, 0, 0, 0, 0, 0, 0, tag); endtask

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (victim_way !== e.way || victim_valid !== e.vv) begin
                fails++;
                $display("FAIL %s: victim_way=%0d victim_valid=%0b expected %0d/%0b",
                         e.tag, victim_way, victim_valid, e.way, e.vv);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < WAYS; i++) begin m_cnt[i] = 0; m_vld[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (victim_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10: victim_valid=%0b during reset expected 0", victim_valid);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        begin
            exp_t e;
            e.due = cyc; e.way = 3'd0; e.vv = 1'b1; e.tag = "R1 R10 post-reset";
            q.push_back(e);
        end
        hit(3, "R8 hit on invalid way ignored");
        for (int w = 0; w < WAYS; w++) fill(w, "R2 fill, lowest invalid next");
        idle("R3 all in zone 1, lowest way");
        for (int w = 0; w < 7; w++) hit(w, "R4 promote one zone");
        hit(7, "R3 tie after uniform promotion");
        hit(0, "R4 promote to top zone");
        hit(0, "R4 saturate at 7");
        hit(0, "R4 stays at 7");
        tick("R5 demote all");
        tick("R5 demote again");
        tick("R5 saturate at 0");
        tick("R5 hold at 0");
        step(1, 2, 0, 0, 0, 0, 1, "R6 tick then hit from 0");
        hit(2, "R4 way2 climbs");
        step(1, 2, 0, 0, 0, 0, 1, "R6 tick then hit keeps value");
        step(1, 1, 1, 1, 0, 0, 0, "R9 fill beats hit");
        step(0, 0, 1, 4, 1, 4, 0, "R7 invalidate beats fill");
        tick("R7 invalid way stays victim");
        hit(4, "R8 hit on invalidated way ignored");
        fill(4, "R2 refill invalidated way");
        step(1, 5, 0, 0, 1, 5, 0, "R7 invalidate beats hit");
        fill(5, "R2 refill way5");
        hit(6, "R3 mixed zones");
        tick("R5 age mixed set");
        tick("R5 age mixed set again");
        idle("R3 final ranking");
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule